// File: doc/BRIEF.md
# HDLC Time-Slot Frame Receiver

This block recovers HDLC frames from a serial line that is only meaningful during a selected time slot. Each received bit is qualified by a bit-clock enable and a slot-window signal. The block looks for opening flags and deletes the zeros that the transmitter inserted. It rebuilds bytes, address field included, and passes them downstream as a stream of bytes. Closing flags and abort sequences mark the end of a frame. Once a frame ends, the block emits one status byte and also keeps a copy of it in a status register. The status byte reports the result of the frame check sequence and how the frame terminated.

The frame check can use the 16-bit or the 32-bit CCITT polynomial. A configuration pin chooses whether the received check-sequence bytes are forwarded downstream or dropped. Flags may be shared between consecutive frames, and adjacent flags may share a zero bit.

The output is a valid/ready stream. While `m_valid` is high and `m_ready` is low, the presented item does not change. The serial side cannot be stalled, so items are queued in a small internal buffer of `Q_DEPTH` entries. Any item produced while that buffer is full is discarded. The consumer must therefore drain the buffer faster than one byte per eight serial bits on average.

Top module: `hdlc_slot_rx`

## Requirements
- R1: Nothing is output until a flag has been followed by at least eight bits that are neither a flag nor an abort. A flag followed directly by another flag or by an abort opens no frame. Bits received while hunting are ignored.
- R2: Inside a frame, a 0 that directly follows five consecutive 1s is deleted. It is not part of the data, the byte count or the CRC.
- R3: A single flag (0 followed by six 1s and a 0) closes one frame and can open the next. Flags that share their boundary 0 bit, as in 011111101111110, count as two flags.
- R4: Frame bytes, address included, are output in arrival order with `m_is_stat`=0. The first received bit of each byte becomes bit 0.
- R5: After the last byte of a frame, one item with `m_is_stat`=1 carries the status byte. Bit 0 means CRC OK, bit 1 means aborted, bit 2 means the bit count is not a multiple of 8, and bits 7..3 are 0. `stat_q` takes the same value in the same cycle that the status item enters the output buffer. `stat_q` is 0 after reset.
- R6: With `cfg_keep_crc`=1, every complete byte of the frame is output. With `cfg_keep_crc`=0, the last 2 complete bytes (CRC-16) or the last 4 complete bytes (CRC-32) are withheld.
- R7: The CRC register starts at all ones and shifts in the data bits in arrival order, MSB feedback. The polynomial is 0x1021 when `cfg_crc32`=0 and 0x04C11DB7 when it is 1. Status bit 0 is set when the register holds 0x1D0F (16-bit) or 0xC704DD7B (32-bit) at the end of the frame.
- R8: Seven consecutive 1s inside a frame end it with status bit 1 set. Only data bits that were received more than seven bits before the abort count toward the bytes and the CRC.
- R9: Leftover bits that do not fill a byte at the end of a frame are discarded and set status bit 2.
- R10: A serial bit is taken only in a cycle where both `ser_en` and `slot_act` are 1.
- R11: `m_valid` is 0 after reset. While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_is_stat` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_crc32 | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| cfg_keep_crc | input | 1 | 1 forwards the received CRC bytes |
| ser_en | input | 1 | Serial bit-clock enable |
| slot_act | input | 1 | High inside the selected time slot |
| ser_bit | input | 1 | Serial data bit |
| m_valid | output | 1 | Output item available |
| m_ready | input | 1 | Consumer accepts the item |
| m_data | output | 8 | Frame byte or status byte |
| m_is_stat | output | 1 | Item is a status byte |
| stat_q | output | 8 | Status of the most recently closed frame |

## Verification
The assertions watch properties that must hold on every cycle. They check that an item held under back-pressure stays stable, that an abort is flagged only once per run of ones, and that a flag empties the bit delay line. They also check that a frame byte never collides with the end-of-frame drain, and that `stat_q` takes exactly the status item pushed in the cycle before. Other behaviours only show up when whole frames are streamed through the block. These are zero deletion, flag sharing, the CRC residue, the withholding of CRC bytes, and the byte counts after an abort or a ragged ending. The bench scenarios drive such frames with random off-slot gaps and random `m_ready` stalls.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC16_POLY = 16'h1021;
  localparam logic [15:0] CRC16_GOOD = 16'h1D0F;
  localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC32_GOOD = 32'hC704_DD7B;

  typedef enum logic [1:0] {FR_HUNT, FR_SYNC, FR_ACTIVE} fr_state_e;

  typedef struct packed {
    logic       is_stat;
    logic [7:0] data;
  } rx_item_t;
endpackage

// File: rtl/hdlc_bit_deframer.sv
module hdlc_bit_deframer #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_take,
  input  logic bit_in,
  output logic flag_ev,
  output logic abort_ev,
  output logic dbit_vld,
  output logic dbit
);
  localparam int DLY = FLAG_ONES + 1;
  localparam int OW  = $clog2(FLAG_ONES + 2);
  localparam int DW  = $clog2(DLY + 1);

  logic [OW-1:0]  ones;
  logic [DLY-1:0] dline;
  logic [DW-1:0]  dcnt;
  logic           stuffed, in_abort, keep;

  always_comb begin
    flag_ev  = bit_take && !bit_in && (ones == OW'(FLAG_ONES));
    abort_ev = bit_take &&  bit_in && (ones == OW'(FLAG_ONES));
    stuffed  = bit_take && !bit_in && (ones == OW'(FLAG_ONES - 1));
    in_abort = ones > OW'(FLAG_ONES);
    keep     = bit_take && !flag_ev && !abort_ev && !stuffed && !in_abort;
    dbit_vld = keep && (dcnt == DW'(DLY));
    dbit     = dline[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones  <= '0;
      dline <= '0;
      dcnt  <= '0;
    end else begin
      if (bit_take) begin
        if (!bit_in) ones <= '0;
        else if (!in_abort) ones <= ones + OW'(1);
      end
      if (flag_ev || abort_ev) begin
        dcnt <= '0;
      end else if (keep) begin
        dline <= {bit_in, dline[DLY-1:1]};
        if (dcnt != DW'(DLY)) dcnt <= dcnt + DW'(1);
      end
    end
  end

  AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !abort_ev); // R8
  AST_FLAG_EMPTIES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ev |=> !dbit_vld); // R1
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  input  logic wide,
  output logic crc_ok
);
  logic [31:0] crc;
  logic [15:0] nxt16;
  logic [31:0] nxt32;

  always_comb begin
    nxt16  = {crc[14:0], 1'b0} ^ ((crc[15] ^ bit_in) ? CRC16_POLY : 16'h0);
    nxt32  = {crc[30:0], 1'b0} ^ ((crc[31] ^ bit_in) ? CRC32_POLY : 32'h0);
    crc_ok = wide ? (crc == CRC32_GOOD) : (crc[15:0] == CRC16_GOOD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '1;
    else if (en)       crc <= wide ? nxt32 : {crc[31:16], nxt16};
  end
endmodule

// File: rtl/hdlc_byte_queue.sv
module hdlc_byte_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  always_comb begin
    out_valid = cnt != '0;
    out_data  = mem[rd];
    do_pop    = out_valid && out_ready;
    do_push   = push && (cnt != (AW+1)'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wr] <= push_data;
        wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + AW'(1);
      end
      if (do_pop) rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
endmodule

// File: rtl/hdlc_slot_rx.sv
module hdlc_slot_rx
  import hdlc_rx_pkg::*;
#(
  parameter int Q_DEPTH  = 8,
  parameter int HOLD_MAX = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_crc32,
  input  logic       cfg_keep_crc,
  input  logic       ser_en,
  input  logic       slot_act,
  input  logic       ser_bit,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_is_stat,
  output logic [7:0] stat_q
);
  localparam int HW = $clog2(HOLD_MAX + 1);

  logic flag_ev, abort_ev, dbit_vld, dbit, crc_ok;
  fr_state_e st;
  logic [7:0] sr, new_byte, stat_byte;
  logic [2:0] bcnt;
  logic [7:0] hold    [HOLD_MAX];
  logic [7:0] hold_sh [HOLD_MAX];
  logic [HW-1:0] hcnt, drain_n, hold_lim;
  logic stat_pend, take_bit, byte_done, byte_push, drain_push, stat_push;
  logic frame_end, q_push;
  rx_item_t q_item, q_out;

  hdlc_bit_deframer #(.FLAG_ONES(6)) u_deframe (
    .clk(clk), .rst_n(rst_n), .bit_take(ser_en && slot_act), .bit_in(ser_bit),
    .flag_ev(flag_ev), .abort_ev(abort_ev), .dbit_vld(dbit_vld), .dbit(dbit));

  hdlc_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(flag_ev || abort_ev), .en(take_bit),
    .bit_in(dbit), .wide(cfg_crc32), .crc_ok(crc_ok));

  for (genvar i = 0; i < HOLD_MAX; i++) begin : g_shift
    if (i == HOLD_MAX - 1) begin : g_top
      assign hold_sh[i] = 8'h00;
    end else begin : g_mid
      assign hold_sh[i] = hold[i+1];
    end
  end

  always_comb begin
    hold_lim   = cfg_crc32 ? HW'(HOLD_MAX) : HW'(HOLD_MAX / 2);
    take_bit   = dbit_vld && (st != FR_HUNT);
    new_byte   = {dbit, sr[7:1]};
    byte_done  = take_bit && (bcnt == 3'd7);
    byte_push  = byte_done && (hcnt == hold_lim);
    drain_push = drain_n != '0;
    stat_push  = !drain_push && stat_pend;
    frame_end  = (flag_ev || abort_ev) && (st == FR_ACTIVE);
    q_push     = byte_push || drain_push || stat_push;
    q_item     = stat_push ? rx_item_t'{is_stat: 1'b1, data: stat_byte}
                           : rx_item_t'{is_stat: 1'b0, data: hold[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FR_HUNT;
      sr        <= '0;
      bcnt      <= '0;
      hcnt      <= '0;
      drain_n   <= '0;
      stat_pend <= 1'b0;
      stat_byte <= '0;
      stat_q    <= '0;
      for (int i = 0; i < HOLD_MAX; i++) hold[i] <= '0;
    end else begin
      if (flag_ev)       st <= FR_SYNC;
      else if (abort_ev) st <= FR_HUNT;
      else if (take_bit) st <= FR_ACTIVE;

      if (flag_ev || abort_ev) begin
        bcnt <= '0;
      end else if (take_bit) begin
        sr   <= new_byte;
        bcnt <= bcnt + 3'd1;
      end

      for (int i = 0; i < HOLD_MAX; i++) begin
        if (byte_push)
          hold[i] <= (HW'(i) == hold_lim - HW'(1)) ? new_byte : hold_sh[i];
        else if (byte_done && HW'(i) == hcnt)
          hold[i] <= new_byte;
        else if (drain_push)
          hold[i] <= hold_sh[i];
      end

      if (flag_ev || abort_ev)          hcnt <= '0;
      else if (byte_done && !byte_push) hcnt <= hcnt + HW'(1);

      if (frame_end)       drain_n <= cfg_keep_crc ? hcnt : '0;
      else if (drain_push) drain_n <= drain_n - HW'(1);

      if (frame_end) begin
        stat_pend <= 1'b1;
        stat_byte <= {5'b0, bcnt != 3'd0, abort_ev, crc_ok};
      end else if (stat_push) begin
        stat_pend <= 1'b0;
        stat_q    <= stat_byte;
      end
    end
  end

  hdlc_byte_queue #(.DEPTH(Q_DEPTH), .W($bits(rx_item_t))) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_item),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(q_out));

  assign m_data    = q_out.data;
  assign m_is_stat = q_out.is_stat;

  AST_NO_PUSH_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && (drain_push || stat_pend))); // R4
  AST_STAT_TO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    stat_push |=> stat_q == $past(q_item.data)); // R5
  AST_DROP_WITHOUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !cfg_keep_crc |=> drain_n == '0); // R6
endmodule

// File: tb/tb_hdlc_slot_rx.sv
`timescale 1ns/1ps
module tb_hdlc_slot_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_crc32 = 1'b0, cfg_keep_crc = 1'b0;
  logic ser_en = 1'b0, slot_act = 1'b0, ser_bit = 1'b0, m_ready = 1'b0;
  logic m_valid, m_is_stat;
  logic [7:0] m_data, stat_q;

  always #10 clk = ~clk;

  hdlc_slot_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_crc32(cfg_crc32), .cfg_keep_crc(cfg_keep_crc),
    .ser_en(ser_en), .slot_act(slot_act), .ser_bit(ser_bit),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_is_stat(m_is_stat), .stat_q(stat_q));

  int n_checks = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  bit fb[$];
  logic [7:0] last_stat = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Scoreboard monitor: new ready value, then compare an item that will transfer
  always @(negedge clk) begin
    logic [8:0] e;
    string t;
    if (rst_n) begin
      m_ready = ($urandom_range(3) != 0);
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected output item", {23'd0, m_is_stat, m_data}, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({m_is_stat, m_data} === e, t, {23'd0, m_is_stat, m_data}, {23'd0, e});
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      ser_en = 1'b0;
      slot_act = 1'b0;
    end
  endtask

  // R10: random off-slot and disabled cycles carry junk bits
  task automatic raw_bit(input bit b);
    int g;
    g = $urandom_range(5);
    if (g == 0) begin
      @(negedge clk); ser_en = 1'b0; slot_act = 1'b1; ser_bit = $urandom_range(1);
    end else if (g == 1) begin
      @(negedge clk); ser_en = 1'b1; slot_act = 1'b0; ser_bit = $urandom_range(1);
    end
    @(negedge clk);
    ser_en = 1'b1; slot_act = 1'b1; ser_bit = b;
  endtask

  task automatic send_flags(input int n);
    raw_bit(1'b0);
    repeat (n) begin
      repeat (6) raw_bit(1'b1);
      raw_bit(1'b0);
    end
  endtask

  task automatic send_abort();
    repeat (7) raw_bit(1'b1);
  endtask

  task automatic send_raw_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) raw_bit(b[k]);
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) fb.push_back(b[k]);
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c;
    logic f;
    c = '1;
    for (int i = 0; i < n; i++) begin
      if (cfg_crc32) begin
        f = c[31] ^ fb[i];
        c = {c[30:0], 1'b0};
        if (f) c = c ^ 32'h04C1_1DB7;
      end else begin
        f = c[15] ^ fb[i];
        c[15:0] = {c[14:0], 1'b0};
        if (f) c[15:0] = c[15:0] ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic add_fcs(input bit corrupt);
    logic [31:0] f;
    int n;
    f = ~crc_of(fb.size());
    n = cfg_crc32 ? 32 : 16;
    for (int k = n - 1; k >= 0; k--) fb.push_back(f[k] ^ (corrupt && k == 0));
  endtask

  task automatic expect_frame(input bit abort, input string tag);
    int nexit, nb, hl, emit;
    logic [31:0] c;
    logic ok;
    logic [7:0] by, st;
    nexit = abort ? fb.size() - 1 : fb.size();
    nb = nexit / 8;
    c = crc_of(nexit);
    ok = cfg_crc32 ? (c == 32'hC704_DD7B) : (c[15:0] == 16'h1D0F);
    hl = cfg_crc32 ? 4 : 2;
    emit = cfg_keep_crc ? nb : ((nb > hl) ? nb - hl : 0);
    for (int j = 0; j < emit; j++) begin
      for (int k = 0; k < 8; k++) by[k] = fb[j*8 + k];
      exp_q.push_back({1'b0, by});
      tag_q.push_back({tag, " R4 R6 frame byte"});
    end
    st = {5'b0, (nexit % 8) != 0, abort, ok};
    exp_q.push_back({1'b1, st});
    tag_q.push_back({tag, " R5 status byte"});
    last_stat = st;
  endtask

  // Expectations first, then the zero-stuffed bits (R2)
  task automatic frame(input bit abort, input string tag);
    int run;
    expect_frame(abort, tag);
    run = 0;
    for (int i = 0; i < fb.size(); i++) begin
      raw_bit(fb[i]);
      run = fb[i] ? run + 1 : 0;
      if (run == 5) begin
        raw_bit(1'b0);
        run = 0;
      end
    end
    if (abort) send_abort();
    fb.delete();
  endtask

  task automatic check_stat(input string tag);
    idle(40);
    chk(stat_q == last_stat, {tag, " R5 status register"}, {24'd0, stat_q}, {24'd0, last_stat});
    chk(exp_q.size() == 0, {tag, " R11 items drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, R11 output stalled");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R11 reset valid", {31'd0, m_valid}, 0);
    chk(stat_q == 8'h00, "R5 reset status register", {24'd0, stat_q}, 0);

    // R1: hunting junk, flag then abort, more junk
    repeat (3) send_raw_byte(8'h55);
    send_flags(1);
    send_abort();
    repeat (2) send_raw_byte(8'hCC);
    // R3: flags sharing zeros before the first frame
    send_flags(3);
    add_byte(8'h03); add_byte(8'hFF); add_byte(8'h7E); add_byte(8'h3F); add_byte(8'hA5);
    add_fcs(1'b0);
    frame(1'b0, "R1 R2 R7 R10 crc16 drop");
    send_flags(1);
    check_stat("R7 crc16 drop");

    cfg_keep_crc = 1'b1;
    send_flags(1);
    add_byte(8'h01); add_byte(8'hF8); add_byte(8'h1F);
    add_fcs(1'b0);
    frame(1'b0, "R6 crc16 keep");
    send_flags(1);
    check_stat("R6 crc16 keep");

    cfg_crc32 = 1'b1;
    send_flags(1);
    add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h00); add_byte(8'h81);
    add_fcs(1'b0);
    frame(1'b0, "R7 crc32 keep");
    send_flags(1);
    check_stat("R7 crc32 keep");

    cfg_keep_crc = 1'b0;
    send_flags(2);
    add_byte(8'h10); add_byte(8'h20); add_byte(8'hFE); add_byte(8'h40); add_byte(8'h3E);
    add_fcs(1'b0);
    frame(1'b0, "R7 crc32 drop");
    send_flags(1);
    check_stat("R6 crc32 drop");

    // R3: back-to-back frames sharing one flag
    cfg_crc32 = 1'b0;
    send_flags(1);
    add_byte(8'hAA); add_byte(8'h7C); add_byte(8'h11);
    add_fcs(1'b0);
    frame(1'b0, "R3 shared flag A");
    send_flags(1);
    add_byte(8'h5A); add_byte(8'hF0); add_byte(8'h0F); add_byte(8'h77);
    add_fcs(1'b0);
    frame(1'b0, "R3 shared flag B");
    send_flags(2);
    check_stat("R3 shared flag");

    // R7: corrupted check sequence
    cfg_keep_crc = 1'b1;
    send_flags(1);
    add_byte(8'h42); add_byte(8'h99);
    add_fcs(1'b1);
    frame(1'b0, "R7 bad crc");
    send_flags(1);
    check_stat("R7 bad crc");

    // R9: three leftover bits before the closing flag
    send_flags(1);
    add_byte(8'h12); add_byte(8'h34); add_byte(8'h56);
    fb.push_back(1'b1); fb.push_back(1'b0); fb.push_back(1'b1);
    frame(1'b0, "R9 ragged end");
    send_flags(1);
    check_stat("R9 ragged end");

    // R8: aborts with and without kept bytes
    send_flags(1);
    add_byte(8'h11); add_byte(8'h22); add_byte(8'h55);
    frame(1'b1, "R8 abort keep");
    send_flags(1);
    check_stat("R8 abort keep");

    cfg_keep_crc = 1'b0;
    send_flags(1);
    add_byte(8'h11); add_byte(8'h22); add_byte(8'h33); add_byte(8'h44); add_byte(8'h55);
    frame(1'b1, "R8 abort drop");
    send_flags(1);
    check_stat("R8 abort drop");

    idle(50);
    chk(exp_q.size() == 0, "R11 all expected items delivered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule